// File: doc/BRIEF.md
# Push-Button Boot-ROM Overlay Controller

This block decides, cycle by cycle, whether an external 8 KB ROM takes over the bottom of a host CPU's 64 KB memory map. A press on a front-panel button is synchronised and edge-detected. The press raises a non-maskable interrupt pulse of fixed length and switches the overlay on. The CPU's interrupt vector therefore lands inside the external ROM. While the overlay is on, every memory access to the low 16 KB is served by the ROM, with its 13-bit address space repeated every 8 KB. The host's own OS ROM is overridden, and the RAM behind that 16 KB is cut off, so writes there are lost.

The ROM code leaves the overlay and returns to it by executing an instruction fetched from the 3000-3FFF window. Any opcode fetch in that window flips the overlay state once the fetch cycle ends. The opcode of the fetch itself still comes from the old mapping. Plain data reads and writes to the window change nothing. The block also watches I/O writes that carry the host's ROM/RAM paging command and keeps the low six bits of the last such write.

All bus strobes are sampled as active-high levels on the block clock. A bus cycle is a run of clocks during which its strobe is held.

Top module: `rom_overlay_ctrl`

## Requirements
- R1: After reset the overlay is off, `nmi_req` is low, `osrom_off`, `rom_sel` and `ram_off` are low, and `page_cfg` is 0.
- R2: A rising edge on `btn_in` produces exactly one `nmi_req` pulse, high for NMI_LEN clocks (default 4), and switches the overlay on.
- R3: Holding the button down produces no further pulse. A new pulse needs a release and then another press.
- R4: While the overlay is on, `rom_sel` is high for any memory cycle (`cpu_mreq`=1) with `cpu_addr[15:14]`=00. `rom_addr` always equals `cpu_addr[12:0]`, so the ROM repeats every 8 KB. Outside 0000-3FFF, or with the overlay off, `rom_sel` is low.
- R5: `ram_off` is high exactly when `rom_sel` is high. `osrom_off` is high for as long as the overlay is on.
- R6: An opcode fetch (`cpu_m1`=1, `cpu_mreq`=1, `cpu_rd`=1) with `cpu_addr[15:12]`=0011 inverts the overlay state. The inversion takes effect on the first clock after the strobes drop. During the fetch, the outputs still reflect the previous state.
- R7: A memory read or write in 3000-3FFF without `cpu_m1`, and an opcode fetch outside that window, leave the overlay state unchanged.
- R8: An I/O write (`cpu_iorq`=1, `cpu_wr`=1) with `cpu_addr[15]`=0 and `cpu_data[7:6]`=10 loads `cpu_data[5:0]` into `page_cfg`. Other I/O writes and all I/O reads leave `page_cfg` unchanged.
- R9: If a button edge and the end of a toggling fetch are acted on at the same clock, the overlay ends up on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| cpu_m1 | input | 1 | Opcode-fetch cycle marker, active high |
| cpu_mreq | input | 1 | Memory request, active high |
| cpu_iorq | input | 1 | I/O request, active high |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| btn_in | input | 1 | Asynchronous button, high when pressed |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| rom_sel | output | 1 | Chip select for the overlay ROM |
| rom_addr | output | 13 | Address into the overlay ROM |
| osrom_off | output | 1 | Disables the host's internal OS ROM |
| ram_off | output | 1 | Disables host RAM for the current access |
| page_cfg | output | 6 | Low six bits of the last snooped paging write |

## Verification
A button edge and the end of a fetch in the toggle window can both act on the overlay register at the same clock edge. The bench arranges this from a state where the overlay is already on. It raises the button and counts the synchroniser's two stages plus the edge detector. It places a fetch at 3FFB so that its strobes drop just before the clock at which the press is acted on. The overlay must read back as on through `rom_sel` at address 0000. A toggle alone would have turned it off. The fetch's own opcode must also be served by the old mapping.

// File: rtl/rom_overlay_pkg.sv
package rom_overlay_pkg;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ROM_AW     = 13;
  localparam int unsigned PAGE_W     = 6;
  // overlay region: top address bits equal to zero (0000-3FFF)
  localparam int unsigned REGION_BITS = 2;
  // toggle window: top nibble equal to 3 (3000-3FFF)
  localparam int unsigned WIN_BITS    = 4;
  localparam logic [WIN_BITS-1:0] WIN_TAG = 4'h3;
  // paging command marker on data bits 7:6
  localparam logic [1:0] PAGE_TAG = 2'b10;

  typedef enum logic [1:0] {
    OVL_HOLD   = 2'b00,
    OVL_SET    = 2'b01,
    OVL_INVERT = 2'b10
  } ovl_cmd_e;
endpackage

// File: rtl/ovl_btn_nmi.sv
module ovl_btn_nmi #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NMI_LEN     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_async,
  output logic press_pulse,
  output logic nmi_o
);
  localparam int unsigned CW = $clog2(NMI_LEN + 1);

  logic [SYNC_STAGES:0] chain_q;
  logic [CW-1:0]        cnt_q;

  generate
    for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= btn_async;
        else chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign press_pulse = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (press_pulse) cnt_q <= CW'(NMI_LEN);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign nmi_o = (cnt_q != '0);

  assert_nmi_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past(press_pulse));
  assert_one_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse |=> !press_pulse);
endmodule

// File: rtl/ovl_fetch_toggle.sv
module ovl_fetch_toggle
  import rom_overlay_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              m1,
  input  logic              mreq,
  input  logic              rd,
  output logic              toggle_o
);
  logic fetch_cyc, win_fetch, pend_q;

  assign fetch_cyc = m1 & mreq & rd;
  assign win_fetch = fetch_cyc & (addr[ADDR_W-1 -: WIN_BITS] == WIN_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (win_fetch) pend_q <= 1'b1;
    else if (!fetch_cyc) pend_q <= 1'b0;
  end

  // fires once the fetch strobes have been released
  assign toggle_o = pend_q & ~fetch_cyc;

  assert_toggle_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_o |-> !(m1 && mreq && rd));
  assert_toggle_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_o |-> $past(m1 && mreq && rd && addr[ADDR_W-1 -: WIN_BITS] == WIN_TAG));
endmodule

// File: rtl/ovl_page_snoop.sv
module ovl_page_snoop
  import rom_overlay_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              iorq,
  input  logic              wr,
  output logic [PAGE_W-1:0] page_o
);
  logic hit;

  assign hit = iorq & wr & ~addr[ADDR_W-1] & (data[DATA_W-1 -: 2] == PAGE_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n)   page_o <= '0;
    else if (hit) page_o <= data[PAGE_W-1:0];
  end

  assert_page_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(iorq && wr) |=> $stable(page_o));
endmodule

// File: rtl/rom_overlay_ctrl.sv
module rom_overlay_ctrl
  import rom_overlay_pkg::*;
#(
  parameter int unsigned NMI_LEN     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_m1,
  input  logic              cpu_mreq,
  input  logic              cpu_iorq,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              btn_in,
  output logic              nmi_req,
  output logic              rom_sel,
  output logic [12:0]       rom_addr,
  output logic              osrom_off,
  output logic              ram_off,
  output logic [5:0]        page_cfg
);
  logic     press, toggle, ovl_q, in_region;
  ovl_cmd_e cmd;

  ovl_btn_nmi #(.SYNC_STAGES(SYNC_STAGES), .NMI_LEN(NMI_LEN)) u_btn (
    .clk(clk), .rst_n(rst_n), .btn_async(btn_in),
    .press_pulse(press), .nmi_o(nmi_req));

  ovl_fetch_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .m1(cpu_m1),
    .mreq(cpu_mreq), .rd(cpu_rd), .toggle_o(toggle));

  ovl_page_snoop u_snoop (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .data(cpu_data),
    .iorq(cpu_iorq), .wr(cpu_wr), .page_o(page_cfg));

  // button press outranks a simultaneous toggle
  always_comb begin
    if (press)       cmd = OVL_SET;
    else if (toggle) cmd = OVL_INVERT;
    else             cmd = OVL_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovl_q <= 1'b0;
    else begin
      case (cmd)
        OVL_SET:    ovl_q <= 1'b1;
        OVL_INVERT: ovl_q <= ~ovl_q;
        default:    ovl_q <= ovl_q;
      endcase
    end
  end

  assign in_region = (cpu_addr[ADDR_W-1 -: REGION_BITS] == '0);
  assign rom_sel   = ovl_q & cpu_mreq & in_region;
  assign ram_off   = ovl_q & cpu_mreq & in_region;
  assign rom_addr  = cpu_addr[ROM_AW-1:0];
  assign osrom_off = ovl_q;

  assert_press_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> osrom_off);
  assert_ovl_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!press && !toggle) |=> $stable(osrom_off));
  assert_ram_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_off |-> (rom_sel && osrom_off));
  assert_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (cpu_addr < 16'h4000));
endmodule

// File: tb/rom_overlay_ctrl_tb.sv
module rom_overlay_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_data = 0;
  logic        cpu_m1 = 0, cpu_mreq = 0, cpu_iorq = 0, cpu_rd = 0, cpu_wr = 0, btn_in = 0;
  logic        nmi_req, rom_sel, osrom_off, ram_off;
  logic [12:0] rom_addr;
  logic [5:0]  page_cfg;
  int n_run = 0, n_fail = 0, nmi_cycles = 0;

  always #10 clk = ~clk;

  rom_overlay_ctrl u_dut (.*);

  always @(negedge clk) if (nmi_req) nmi_cycles++;

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_m1 = 0; cpu_mreq = 0; cpu_iorq = 0; cpu_rd = 0; cpu_wr = 0;
  endtask

  // combinational look at the mapping, no clock edge passes
  task automatic probe(input logic [15:0] a, output logic sel);
    cpu_addr = a; cpu_mreq = 1; cpu_rd = 1; cpu_m1 = 0;
    #1 sel = rom_sel;
    idle();
  endtask

  task automatic fetch(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_m1 = 1; cpu_mreq = 1; cpu_rd = 1;
    @(negedge clk); idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic s;
    check("R1 nmi", nmi_req, 0);
    check("R1 page", page_cfg, 0);
    check("R1 osrom", osrom_off, 0);
    probe(16'h0000, s);
    check("R1 rom_sel", s, 0);
    check("R1 ram_off", ram_off, 0);
  endtask

  task automatic t_press();
    logic s;
    int base;
    base = nmi_cycles;
    @(negedge clk); btn_in = 1;
    repeat (15) @(negedge clk);
    check("R2 nmi length", nmi_cycles - base, 4);
    check("R2 overlay on", osrom_off, 1);
    probe(16'h0100, s);
    check("R2 rom_sel", s, 1);
    repeat (10) @(negedge clk);
    check("R3 held no repeat", nmi_cycles - base, 4);
    btn_in = 0;
    repeat (6) @(negedge clk);
    check("R3 release no pulse", nmi_cycles - base, 4);
  endtask

  task automatic t_map();
    logic s;
    probe(16'h2ABC, s);
    check("R4 mirror sel", s, 1);
    cpu_addr = 16'h2ABC; #1;
    check("R4 mirror addr", rom_addr, 13'h0ABC);
    cpu_mreq = 1; cpu_wr = 1; cpu_addr = 16'h3FFB; #1;
    check("R5 ram_off write", ram_off, 1);
    idle();
    probe(16'h4000, s);
    check("R4 above region", s, 0);
    cpu_addr = 16'h4000; cpu_mreq = 1; #1;
    check("R5 ram_off above", ram_off, 0);
    idle();
    check("R5 osrom_off", osrom_off, 1);
  endtask

  task automatic t_toggle();
    logic s;
    // overlay currently on; fetch at 3000 turns it off
    @(negedge clk);
    cpu_addr = 16'h3000; cpu_m1 = 1; cpu_mreq = 1; cpu_rd = 1; #1;
    check("R6 old map during fetch", rom_sel, 1);
    @(negedge clk); #1;
    check("R6 still old after edge", rom_sel, 1);
    idle();
    @(negedge clk);
    probe(16'h0000, s);
    check("R6 toggled off", s, 0);
    check("R6 osrom off", osrom_off, 0);
    fetch(16'h3FFB);
    probe(16'h0000, s);
    check("R6 toggled on", s, 1);
  endtask

  task automatic t_no_toggle();
    logic s;
    @(negedge clk); cpu_addr = 16'h3500; cpu_mreq = 1; cpu_rd = 1;
    @(negedge clk); idle();
    @(negedge clk); cpu_addr = 16'h3600; cpu_mreq = 1; cpu_wr = 1;
    @(negedge clk); idle();
    @(negedge clk);
    check("R7 data access", osrom_off, 1);
    fetch(16'h4000);
    fetch(16'h2FFF);
    probe(16'h0000, s);
    check("R7 fetch outside", s, 1);
  endtask

  task automatic t_snoop();
    @(negedge clk); cpu_addr = 16'h7F00; cpu_data = 8'h8D; cpu_iorq = 1; cpu_wr = 1;
    @(negedge clk); idle();
    check("R8 load", page_cfg, 6'h0D);
    cpu_addr = 16'h7F00; cpu_data = 8'hC5; cpu_iorq = 1; cpu_wr = 1;
    @(negedge clk); idle();
    check("R8 tag 11 ignored", page_cfg, 6'h0D);
    cpu_addr = 16'hFF00; cpu_data = 8'h85; cpu_iorq = 1; cpu_wr = 1;
    @(negedge clk); idle();
    check("R8 addr15 ignored", page_cfg, 6'h0D);
    cpu_addr = 16'h7F00; cpu_data = 8'h89; cpu_iorq = 1; cpu_rd = 1;
    @(negedge clk); idle();
    check("R8 read ignored", page_cfg, 6'h0D);
  endtask

  task automatic t_collide();
    logic s;
    int base;
    check("R9 precondition", osrom_off, 1);
    base = nmi_cycles;
    @(negedge clk); btn_in = 1;
    @(negedge clk);
    cpu_addr = 16'h3FFB; cpu_m1 = 1; cpu_mreq = 1; cpu_rd = 1; #1;
    check("R9 fetch old map", rom_sel, 1);
    @(negedge clk); idle();
    @(negedge clk);
    probe(16'h0000, s);
    check("R9 press wins", s, 1);
    btn_in = 0;
    repeat (10) @(negedge clk);
    check("R9 nmi pulse", nmi_cycles - base, 4);
    check("R9 stays on", osrom_off, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_press();
    t_map();
    t_toggle();
    t_no_toggle();
    t_snoop();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule